// File: doc/BRIEF.md
# Shift-Load Read Buffer

This block sits inside one core, between a rotating shared memory that delivers one 32-bit word per granted slot and a consumer that reads words at its own pace, such as a pixel streamer or an instruction fetcher. It holds up to twenty words. The oldest word always lives in stage 0 and is presented on the head output. Consumption therefore needs no read pointer and no output multiplexer.

Every stage has a two-way input choice: the incoming memory word or the word of the stage just above it. A pop shifts the whole queue one place toward the head. A push writes the new word into the first free stage, and that stage is indexed by the occupancy counter itself. A fetch-request output tells the memory side when a full 16-word burst, added to the words already requested, would still fit. A flush input empties the buffer in one cycle, for example on a taken branch.

Top module: `shlf_fifo`

## Requirements
- R1: After synchronous reset, `count` is 0, `head_valid` is 0 and `overflow` is 0.
- R2: A push without an effective pop, with `count` below 20, stores `wr_data` behind all held words and raises `count` by one on the next clock.
- R3: A push without an effective pop while `count` is 20 is ignored: count and contents stay unchanged, and `overflow` is 1 for exactly the following cycle.
- R4: A pop without a push, with `count` above 0, lowers `count` by one, and the next-oldest word appears on `head_data`. A pop while empty is ignored.
- R5: A push and an effective pop in the same cycle leave `count` unchanged and keep arrival order, including when the buffer is full. When the buffer is empty, the pair acts as a push alone.
- R6: `head_valid` and the pushed word appear on the clock right after the first word is pushed into an empty buffer, with no wait for further words.
- R7: Pops on consecutive clocks drain one word per clock in arrival order.
- R8: `flush` sets `count` to 0 on the next clock and discards any push or pop in the same cycle. `overflow` stays 0 in that cycle.
- R9: `fetch_req` is 1 exactly when `count + inflight` is at most 20 - 16 = 4 (combinational, same cycle).
- R10: `count` always equals the number of words held and never exceeds 20. `head_valid` is 1 exactly when `count` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all held words |
| push | input | 1 | Memory word arrives this cycle |
| wr_data | input | 32 | Memory read word |
| pop | input | 1 | Consumer takes the head word |
| inflight | input | 5 | Words requested but not yet delivered |
| head_data | output | 32 | Oldest held word (stage 0) |
| head_valid | output | 1 | Buffer is not empty |
| count | output | 5 | Words held; also the next write stage |
| overflow | output | 1 | One-cycle pulse for a dropped push |
| fetch_req | output | 1 | A 16-word burst would fit |

## Verification
The push and the pop can fall in the same cycle. Then the shift and the write land on adjacent stage selections, and the write moves to stage count-1. The bench provokes this directly at full and at empty, and in a long random phase where both strobes are drawn independently each cycle. Each result is judged against a queue model that applies the pop before the push, by comparing the count, the head word and the overflow pulse after the clock.

// File: rtl/shlf_pkg.sv
package shlf_pkg;

    // Source selection for one storage stage.
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_MEM   = 2'd1,
        SRC_ABOVE = 2'd2
    } src_e;

    // Qualified strobes for one cycle.
    typedef struct packed {
        logic push_ok;
        logic pop_eff;
        logic drop;
    } op_t;

    function automatic op_t decode_op(
        input logic push,
        input logic pop,
        input logic flush,
        input logic empty,
        input logic full
    );
        op_t o;
        o.pop_eff = pop && !empty && !flush;
        o.push_ok = push && !flush && (!full || o.pop_eff);
        o.drop    = push && !flush && full && !o.pop_eff;
        return o;
    endfunction

endpackage

// File: rtl/shlf_stage.sv
module shlf_stage
    import shlf_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  src_e             sel,
    input  logic [WIDTH-1:0] mem_d,
    input  logic [WIDTH-1:0] above_d,
    output logic [WIDTH-1:0] q
);
    // Data stages carry no reset: validity is tracked by the counter.
    always_ff @(posedge clk) begin
        case (sel)
            SRC_MEM:   q <= mem_d;
            SRC_ABOVE: q <= above_d;
            default:   q <= q;
        endcase
    end
endmodule

// File: rtl/shlf_ctrl.sv
module shlf_ctrl
    import shlf_pkg::*;
#(
    parameter int DEPTH = 20,
    parameter int BURST = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [CNT_W-1:0] inflight,
    output src_e             sel_o [DEPTH],
    output logic [CNT_W-1:0] count_o,
    output logic             overflow_o,
    output logic             fetch_req_o
);
    localparam logic [CNT_W:0] FETCH_LIMIT = (CNT_W + 1)'(DEPTH - BURST);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wr_idx;
    logic             ovf_q;
    op_t              op;

    assign op     = decode_op(push, pop, flush, cnt_q == '0, cnt_q == CNT_W'(DEPTH));
    assign wr_idx = op.pop_eff ? cnt_q - 1'b1 : cnt_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (op.push_ok && wr_idx == CNT_W'(i))
                sel_o[i] = SRC_MEM;
            else if (op.pop_eff && i < DEPTH - 1)
                sel_o[i] = SRC_ABOVE;
            else
                sel_o[i] = SRC_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= op.drop;
            if (flush)
                cnt_q <= '0;
            else if (op.push_ok && !op.pop_eff)
                cnt_q <= cnt_q + 1'b1;
            else if (op.pop_eff && !op.push_ok)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count_o     = cnt_q;
    assign overflow_o  = ovf_q;
    assign fetch_req_o = ({1'b0, cnt_q} + {1'b0, inflight}) <= FETCH_LIMIT;
endmodule

// File: rtl/shlf_fifo.sv
module shlf_fifo
    import shlf_pkg::*;
#(
    parameter int DEPTH = 20,
    parameter int WIDTH = 32,
    parameter int BURST = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    input  logic [CNT_W-1:0] inflight,
    output logic [WIDTH-1:0] head_data,
    output logic             head_valid,
    output logic [CNT_W-1:0] count,
    output logic             overflow,
    output logic             fetch_req
);
    src_e             sel   [DEPTH];
    logic [WIDTH-1:0] stg_q [DEPTH];

    shlf_ctrl #(.DEPTH(DEPTH), .BURST(BURST)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .push        (push),
        .pop         (pop),
        .inflight    (inflight),
        .sel_o       (sel),
        .count_o     (count),
        .overflow_o  (overflow),
        .fetch_req_o (fetch_req)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic [WIDTH-1:0] above;
        if (g == DEPTH - 1) begin : g_top
            assign above = '0;
        end else begin : g_mid
            assign above = stg_q[g+1];
        end
        shlf_stage #(.WIDTH(WIDTH)) stage_i (
            .clk     (clk),
            .sel     (sel[g]),
            .mem_d   (wr_data),
            .above_d (above),
            .q       (stg_q[g])
        );
    end

    assign head_data  = stg_q[0];
    assign head_valid = count != '0;
endmodule

// File: rtl/shlf_fifo_chk.sv
module shlf_fifo_chk #(
    parameter int DEPTH = 20,
    parameter int WIDTH = 32,
    parameter int BURST = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic             push,
    input logic [WIDTH-1:0] wr_data,
    input logic             pop,
    input logic [CNT_W-1:0] inflight,
    input logic [WIDTH-1:0] head_data,
    input logic             head_valid,
    input logic [CNT_W-1:0] count,
    input logic             overflow,
    input logic             fetch_req
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        count <= FULL);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count == '0 && !overflow));

    p_push_r2: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && count < FULL) |=> count == $past(count) + 1'b1);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && count == FULL) |=> (overflow && $stable(count)));

    p_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !flush && count != '0) |=> count == $past(count) - 1'b1);

    p_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !flush && count != '0) |=> $stable(count));

    p_first_word_r6: assert property (@(posedge clk) disable iff (rst)
        (push && !flush && count == '0) |=> (head_valid && head_data == $past(wr_data)));

    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && !overflow));

    p_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (count <= CNT_W'(DEPTH - BURST)));
endmodule

bind shlf_fifo shlf_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BURST(BURST)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .push       (push),
    .wr_data    (wr_data),
    .pop        (pop),
    .inflight   (inflight),
    .head_data  (head_data),
    .head_valid (head_valid),
    .count      (count),
    .overflow   (overflow),
    .fetch_req  (fetch_req)
);

// File: tb/shlf_fifo_tb_top.sv
module shlf_fifo_tb_top;
    localparam int DEPTH = 20;
    localparam int WIDTH = 32;
    localparam int BURST = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic             push = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             pop = 1'b0;
    logic [CNT_W-1:0] inflight = '0;
    logic [WIDTH-1:0] head_data;
    logic             head_valid;
    logic [CNT_W-1:0] count;
    logic             overflow;
    logic             fetch_req;

    int nchecks = 0;
    int nerr = 0;

    logic [WIDTH-1:0] mq [DEPTH];
    int               mcnt = 0;
    bit               mov = 0;

    always #4 clk = ~clk;

    shlf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BURST(BURST)) dut_i (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .wr_data(wr_data),
        .pop(pop), .inflight(inflight), .head_data(head_data),
        .head_valid(head_valid), .count(count), .overflow(overflow),
        .fetch_req(fetch_req)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_fetch(input int c, input int infl);
        return (c + infl) <= (DEPTH - BURST);
    endfunction

    task automatic model_step(input bit p, input bit q, input bit f, input logic [WIDTH-1:0] d);
        mov = 0;
        if (f) begin
            mcnt = 0;
        end else begin
            if (q && mcnt > 0) begin
                for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i+1];
                mcnt--;
            end
            if (p) begin
                if (mcnt < DEPTH) begin
                    mq[mcnt] = d;
                    mcnt++;
                end else begin
                    mov = 1;
                end
            end
        end
    endtask

    task automatic cycle(input string tag, input bit p, input bit q, input bit f,
                         input logic [WIDTH-1:0] d, input int infl);
        push = p; pop = q; flush = f; wr_data = d; inflight = CNT_W'(infl);
        #1;
        chk("R9 fetch_req", fetch_req, exp_fetch(mcnt, infl));
        @(posedge clk);
        model_step(p, q, f, d);
        @(negedge clk);
        chk("R10 count", count, mcnt);
        chk({tag, " head_valid"}, head_valid, mcnt != 0);
        if (mcnt != 0) chk({tag, " head_data"}, head_data, mq[0]);
        chk({tag, " overflow"}, overflow, mov);
    endtask

    initial begin
        #(8 * 200000);
        nerr++;
        nchecks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 head_valid", head_valid, 0);
        chk("R1 overflow", overflow, 0);

        // R6 first word visible next clock
        cycle("R6", 1, 0, 0, 32'hA5A5_0001, 0);
        // R2 fill up to full, exercising fetch_req boundary
        for (int k = 1; k < DEPTH; k++)
            cycle("R2", 1, 0, 0, 32'h1000_0000 + k, k % 3);
        // R3 push at full dropped
        cycle("R3", 1, 0, 0, 32'hDEAD_0001, 0);
        cycle("R3", 1, 0, 0, 32'hDEAD_0002, 0);
        cycle("R3 idle", 0, 0, 0, 0, 0);
        // R5 push and pop together at full
        cycle("R5 full", 1, 1, 0, 32'h5555_0001, 0);
        // R7 back-to-back drain, then R4 pop on empty
        for (int k = 0; k < DEPTH; k++)
            cycle("R7", 0, 1, 0, 0, 0);
        cycle("R4 empty pop", 0, 1, 0, 0, 0);
        // R5 pair at empty acts as push
        cycle("R5 empty", 1, 1, 0, 32'h7777_0001, 0);
        cycle("R4", 1, 0, 0, 32'h7777_0002, 4);
        cycle("R4", 0, 1, 0, 0, 3);
        // R8 flush discards same-cycle push
        cycle("R2", 1, 0, 0, 32'h8888_0001, 0);
        cycle("R8", 1, 1, 1, 32'h8888_0002, 0);
        // R8 flush at full with push: no overflow
        for (int k = 0; k < DEPTH; k++)
            cycle("R2", 1, 0, 0, 32'h9000_0000 + k, 0);
        cycle("R8 full", 1, 0, 1, 32'h9999_0001, 0);

        // random mix
        for (int k = 0; k < 2000; k++) begin
            bit p, q, f;
            p = ($urandom_range(0, 99) < 55);
            q = ($urandom_range(0, 99) < 50);
            f = ($urandom_range(0, 99) < 2);
            cycle("R5 mix", p, q, f, $urandom(), $urandom_range(0, 16));
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end
endmodule